// File: doc/BRIEF.md
# Dual-Rail Four-Phase Channel Bridge

This block joins the clocked part of a chip to a delay-insensitive link. On the transmit side it takes words from a valid/ready stream and turns each one into a dual-rail token. Every bit travels on its own pair of wires: one wire of the pair stands for 0, the other stands for 1, and both low means the pair carries nothing. The token then passes through a parameterised chain of elastic token stages to the transmit pins. A single enable wire from the far receiver paces the transfer. On the receive side it watches an incoming set of rail pairs. It captures a word only once every pair holds a value, and it raises its own enable again once the channel has returned to the empty state and the word has been taken by the clocked consumer.

The transfer on each side follows a four-phase cycle. The sender asserts the code. The receiver takes it and drops enable. The sender clears all rails to empty. The receiver restores enable when it can accept the next token. The token stages behave as clocked C-element half buffers. They hold a token until the next stage has taken it, and they reset to the empty state. Because of this, the number of stages changes latency and buffering but never the words delivered or their order. A pair with both wires high is illegal and is flagged.

Top module: `dr_bridge`

## Requirements
- R1: Encoding on the transmit pins. A sent word bit b of value 1 shows as tx_rail1[b]=1 and tx_rail0[b]=0. A bit of value 0 shows as tx_rail0[b]=1 and tx_rail1[b]=0. When both rails of a pair are 0, the pair carries no data.
- R2: The transmit pins hold a token for as long as tx_en stays high. After tx_en falls, every transmit rail returns to 0.
- R3: When every rx pair holds exactly one high rail, the receiver captures the word. On the next clock edge rx_en goes low, m_valid goes high, and m_data equals rx_rail1.
- R4: While any rx pair is still empty, no word is captured: m_valid stays low and rx_en stays high.
- R5: rx_en rises only after all rx pairs are empty and the captured word has been consumed (m_valid and m_ready high) or is consumed in the same cycle.
- R6: A pair with both rails high never counts as valid. rx_err is high in each cycle that follows a cycle in which the rx rails held such a pair, and only then.
- R7: While m_valid is high and m_ready is low, m_valid stays high and m_data does not change.
- R8: Reset empties every token stage and returns the sender to idle. During reset and right after it, all transmit rails are 0, s_ready is 1, rx_en is 1, m_valid is 0 and rx_err is 0.
- R9: When the transmit pins are looped back to the receive pins and tx_en is fed from rx_en, the words delivered on m_data equal the accepted s_data words, in order, for any receiver stall pattern.
- R10: The transmit side never drives both rails of one pair high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_valid | input | 1 | Send-side word valid |
| s_ready | output | 1 | Sender accepts a word |
| s_data | input | W | Word to send |
| tx_rail0 | output | W | Transmit rails meaning 0 |
| tx_rail1 | output | W | Transmit rails meaning 1 |
| tx_en | input | 1 | Enable from far receiver |
| rx_rail0 | input | W | Receive rails meaning 0 |
| rx_rail1 | input | W | Receive rails meaning 1 |
| rx_en | output | 1 | Enable to far sender |
| m_valid | output | 1 | Received word valid |
| m_ready | input | 1 | Consumer takes the word |
| m_data | output | W | Received word |
| rx_err | output | 1 | Illegal both-high pair seen |

## Verification
The checker watches, on every cycle, the properties that follow from the handshake itself. The transmit pins must never show a both-high pair. A fall of rx_en must follow a complete incoming word, and a rise of rx_en must follow an empty channel. The illegal-code flag must match the rails seen in the previous cycle. A stalled output word must stay held. Other properties need a chosen stimulus, so only the bench scenarios can show them. These are: the pin encoding of a specific word, return-to-zero once enable drops, refusal of a partial word, the hold of enable while a captured word waits unconsumed, stages emptied by a reset in mid-transfer, and end-to-end order through the stage chain under varied consumer stalls.

// File: rtl/dr_pkg.sv
package dr_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_RTZ  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_FILL  = 1'b0,
        RX_DRAIN = 1'b1
    } rx_state_e;
endpackage

// File: rtl/dr_encoder.sv
module dr_encoder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    input  logic         en_in,
    output logic [W-1:0] rail0,
    output logic [W-1:0] rail1
);
    import dr_pkg::*;

    typedef struct packed {
        tx_state_e    st;
        logic [W-1:0] r0;
        logic [W-1:0] r1;
    } enc_t;

    enc_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (s_valid && en_in) begin
                    d.st = TX_SEND;
                    d.r1 = s_data;
                    d.r0 = ~s_data;
                end
            end
            TX_SEND: begin
                if (!en_in) begin
                    d.st = TX_RTZ;
                    d.r0 = '0;
                    d.r1 = '0;
                end
            end
            TX_RTZ: begin
                if (en_in) d.st = TX_IDLE;
            end
            default: begin
                d.st = TX_IDLE;
                d.r0 = '0;
                d.r1 = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st <= TX_IDLE;
            q.r0 <= '0;
            q.r1 <= '0;
        end else begin
            q <= d;
        end
    end

    assign s_ready = (q.st == TX_IDLE) && en_in;
    assign rail0   = q.r0;
    assign rail1   = q.r1;
endmodule

// File: rtl/dr_stage.sv
module dr_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_r0,
    input  logic [W-1:0] in_r1,
    output logic         en_up,
    output logic [W-1:0] out_r0,
    output logic [W-1:0] out_r1,
    input  logic         en_dn
);
    typedef struct packed {
        logic [W-1:0] r0;
        logic [W-1:0] r1;
        logic         en;
    } stg_t;

    stg_t q, d;
    logic held_full, held_empty;
    logic [W-1:0] en_vec;

    assign en_vec     = {W{en_dn}};
    assign held_full  = &(q.r0 | q.r1);
    assign held_empty = ~|(q.r0 | q.r1);

    always_comb begin
        d = q;
        // per-rail Muller element: set on input and enable, clear on neither
        d.r0 = (in_r0 & en_vec) | (q.r0 & (in_r0 | en_vec));
        d.r1 = (in_r1 & en_vec) | (q.r1 & (in_r1 | en_vec));
        // completion with hysteresis drives the upstream enable
        if (held_full)       d.en = 1'b0;
        else if (held_empty) d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.r0 <= '0;
            q.r1 <= '0;
            q.en <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign out_r0 = q.r0;
    assign out_r1 = q.r1;
    assign en_up  = q.en;
endmodule

// File: rtl/dr_decoder.sv
module dr_decoder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rail0,
    input  logic [W-1:0] rail1,
    output logic         en_out,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data,
    output logic         err
);
    import dr_pkg::*;

    typedef struct packed {
        rx_state_e    st;
        logic         en;
        logic         vld;
        logic [W-1:0] dat;
        logic         err;
    } dec_t;

    dec_t q, d;
    logic word_full, word_empty, bad_pair, consume;

    assign word_full  = &(rail0 ^ rail1);
    assign word_empty = ~|(rail0 | rail1);
    assign bad_pair   = |(rail0 & rail1);
    assign consume    = q.vld && m_ready;

    always_comb begin
        d     = q;
        d.err = bad_pair;
        if (consume) d.vld = 1'b0;
        case (q.st)
            RX_FILL: begin
                if (word_full) begin
                    d.st  = RX_DRAIN;
                    d.vld = 1'b1;
                    d.dat = rail1;
                    d.en  = 1'b0;
                end
            end
            RX_DRAIN: begin
                if (word_empty && (!q.vld || consume)) begin
                    d.st = RX_FILL;
                    d.en = 1'b1;
                end
            end
            default: begin
                d.st = RX_FILL;
                d.en = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= RX_FILL;
            q.en  <= 1'b1;
            q.vld <= 1'b0;
            q.dat <= '0;
            q.err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign en_out  = q.en;
    assign m_valid = q.vld;
    assign m_data  = q.dat;
    assign err     = q.err;
endmodule

// File: rtl/dr_bridge.sv
module dr_bridge #(
    parameter int W      = 8,
    parameter int STAGES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic [W-1:0] tx_rail0,
    output logic [W-1:0] tx_rail1,
    input  logic         tx_en,
    input  logic [W-1:0] rx_rail0,
    input  logic [W-1:0] rx_rail1,
    output logic         rx_en,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data,
    output logic         rx_err
);
    localparam int NODES = STAGES + 1;

    logic [W-1:0] c_r0 [NODES];
    logic [W-1:0] c_r1 [NODES];
    logic         c_en [NODES];

    dr_encoder #(.W(W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_data  (s_data),
        .en_in   (c_en[0]),
        .rail0   (c_r0[0]),
        .rail1   (c_r1[0])
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_chain
        dr_stage #(.W(W)) u_stg (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_r0  (c_r0[i]),
            .in_r1  (c_r1[i]),
            .en_up  (c_en[i]),
            .out_r0 (c_r0[i+1]),
            .out_r1 (c_r1[i+1]),
            .en_dn  (c_en[i+1])
        );
    end

    assign c_en[STAGES] = tx_en;
    assign tx_rail0     = c_r0[STAGES];
    assign tx_rail1     = c_r1[STAGES];

    dr_decoder #(.W(W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .rail0   (rx_rail0),
        .rail1   (rx_rail1),
        .en_out  (rx_en),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .m_data  (m_data),
        .err     (rx_err)
    );
endmodule

// File: rtl/dr_bridge_chk.sv
module dr_bridge_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] tx_rail0,
    input logic [W-1:0] tx_rail1,
    input logic [W-1:0] rx_rail0,
    input logic [W-1:0] rx_rail1,
    input logic         rx_en,
    input logic         m_valid,
    input logic         m_ready,
    input logic [W-1:0] m_data,
    input logic         rx_err
);
    assert_tx_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_rail0 & tx_rail1) == '0));

    assert_fall_after_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_en) |-> $past(&(rx_rail0 ^ rx_rail1)));

    assert_rise_after_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> $past((rx_rail0 | rx_rail1) == '0));

    assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    assert_err_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_rail0 & rx_rail1)) |=> rx_err);

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> $past(|(rx_rail0 & rx_rail1)));
endmodule

bind dr_bridge dr_bridge_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_rail0 (tx_rail0),
    .tx_rail1 (tx_rail1),
    .rx_rail0 (rx_rail0),
    .rx_rail1 (rx_rail1),
    .rx_en    (rx_en),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .rx_err   (rx_err)
);

// File: tb/sim_dr_bridge.sv
`timescale 1ns/1ps
module sim_dr_bridge;
    localparam int W  = 8;
    localparam int ST = 3;
    localparam int NV = 12;
    // each entry: {word[11:4], consumer stall cycles[3:0]}
    localparam logic [11:0] VEC [NV] = '{
        {8'h00, 4'd0}, {8'hFF, 4'd0}, {8'hA5, 4'd2}, {8'h5A, 4'd0},
        {8'h01, 4'd5}, {8'h80, 4'd1}, {8'h7E, 4'd0}, {8'hC3, 4'd3},
        {8'h3C, 4'd0}, {8'h55, 4'd7}, {8'hAA, 4'd0}, {8'h0F, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic         s_valid, s_ready, tx_en, rx_en, m_valid, m_ready, rx_err;
    logic [W-1:0] s_data, tx_rail0, tx_rail1, rx_rail0, rx_rail1, m_data;
    logic         inject, tx_en_drv;
    logic [W-1:0] inj_r0, inj_r1;

    assign rx_rail0 = inject ? inj_r0 : tx_rail0;
    assign rx_rail1 = inject ? inj_r1 : tx_rail1;
    assign tx_en    = inject ? tx_en_drv : rx_en;

    dr_bridge #(.W(W), .STAGES(ST)) u0 (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .tx_rail0(tx_rail0), .tx_rail1(tx_rail1), .tx_en(tx_en),
        .rx_rail0(rx_rail0), .rx_rail1(rx_rail1), .rx_en(rx_en),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .rx_err(rx_err)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] w);
        s_data  = w;
        s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        s_valid = 0; s_data = '0; m_ready = 0;
        inject = 0; tx_en_drv = 1; inj_r0 = '0; inj_r1 = '0;
        repeat (3) @(negedge clk);
        // R8: state during reset
        chk("R8", "tx rails", {tx_rail1, tx_rail0}, 32'h0);
        chk("R8", "s_ready", s_ready, 1);
        chk("R8", "rx_en", rx_en, 1);
        chk("R8", "m_valid", m_valid, 0);
        chk("R8", "rx_err", rx_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: loopback through the stage chain, table-driven
        fork
            begin
                for (int i = 0; i < NV; i++) push(VEC[i][11:4]);
            end
            begin
                for (int i = 0; i < NV; i++) begin
                    m_ready = 1'b0;
                    repeat (int'(VEC[i][3:0])) @(negedge clk);
                    m_ready = 1'b1;
                    while (!m_valid) @(negedge clk);
                    chk("R9", "looped word", m_data, VEC[i][11:4]);
                    @(negedge clk);
                end
                m_ready = 1'b0;
            end
        join
        repeat (6) @(negedge clk);

        // R1/R2: pin encoding and return to zero, receiver isolated
        inject = 1'b1; tx_en_drv = 1'b1;
        push(8'hA5);
        repeat (12) @(negedge clk);
        chk("R1", "tx_rail1", tx_rail1, 8'hA5);
        chk("R1", "tx_rail0", tx_rail0, 8'h5A);
        chk("R10", "no both-high", tx_rail0 & tx_rail1, 0);
        tx_en_drv = 1'b0;
        repeat (12) @(negedge clk);
        chk("R2", "rails after enable low", {tx_rail1, tx_rail0}, 32'h0);
        tx_en_drv = 1'b1;
        repeat (12) @(negedge clk);

        // R6: illegal pair on bit 0
        inj_r1 = 8'h01; inj_r0 = 8'hFF;
        @(negedge clk);
        chk("R6", "rx_err set", rx_err, 1);
        @(negedge clk);
        chk("R6", "no capture", m_valid, 0);
        chk("R6", "rx_en kept", rx_en, 1);
        inj_r1 = '0; inj_r0 = '0;
        @(negedge clk);
        chk("R6", "rx_err clear", rx_err, 0);

        // R4: partial word (bits 7:6 empty)
        inj_r1 = 8'h0F; inj_r0 = 8'h30;
        repeat (3) @(negedge clk);
        chk("R4", "partial m_valid", m_valid, 0);
        chk("R4", "partial rx_en", rx_en, 1);

        // R3: complete word
        inj_r0 = 8'hF0;
        @(negedge clk);
        chk("R3", "rx_en low", rx_en, 0);
        chk("R3", "m_valid", m_valid, 1);
        chk("R3", "m_data", m_data, 8'h0F);

        // R5/R7: empty channel, word not yet consumed
        inj_r1 = '0; inj_r0 = '0;
        repeat (3) @(negedge clk);
        chk("R5", "enable held", rx_en, 0);
        chk("R7", "word held", {m_valid, m_data}, {1'b1, 8'h0F});
        m_ready = 1'b1;
        @(negedge clk);
        chk("R5", "enable reopened", rx_en, 1);
        chk("R5", "word taken", m_valid, 0);
        m_ready = 1'b0;

        // R8: reset in mid-transfer empties the stages
        push(8'h66);
        repeat (12) @(negedge clk);
        chk("R8", "token at pins", tx_rail1, 8'h66);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8", "stages empty", {tx_rail1, tx_rail0}, 32'h0);
        chk("R8", "s_ready after reset", s_ready, 1);
        rst_n = 1'b1;
        inject = 1'b0;
        @(negedge clk);

        // R9: traffic after reset
        fork
            push(8'h99);
            begin
                m_ready = 1'b1;
                while (!m_valid) @(negedge clk);
                chk("R9", "word after reset", m_data, 8'h99);
                @(negedge clk);
                m_ready = 1'b0;
            end
        join

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule